// File: doc/BRIEF.md
# System Counter Control Register Frame

This block is the bus-facing control frame of a free-running system counter. It sits on a zero-wait-state APB port and holds the configuration that the separate counter datapath consumes. That configuration is the count enable, the debug-halt enable, the scaling enable and two 32-bit step values. The 64-bit count is shown as two 32-bit words. A write to either word produces a one-cycle load strobe toward the datapath. Read-only status reports a halt indication, the two implementation options and the live clock-select code.

Every access phase is checked in two ways. The first check compares the non-secure bit of the protection attribute against the attribute the frame was built with. The second check is that the address decodes to one of the six registers. Either failure blocks the write, forces the read data to zero and sets a sticky pending flag. The pending flag drives an interrupt through an enable bit. The APB error response is returned only for an attribute mismatch, and only when the error-response enable is set.

Top module: `cnt_ctl_apb`

## Requirements
- R1: After reset, all control bits and the pending flag are 0, the step outputs equal their reset parameters, irq_o and pslverr_o are 0, and pready_o is 1.
- R2: Control word at offset 0x00 uses these bits: bit0 count enable, bit1 debug-halt enable, bit2 scaling enable, bit3 interrupt enable, bit4 error-response enable, bit5 pending. Bits 0 to 4 are read/write and drive their outputs from the cycle after the write.
- R3: Status word at offset 0x04 is read-only. Bit0 is halted_i, bit1 is SCALE_IMPL, bit2 is SWITCH_IMPL, bits 5:4 are clk_sel_i, and all other bits read 0. Writes to it change nothing and raise no error.
- R4: Offsets 0x08 and 0x0C read the low and high halves of cnt_val_i. A valid write to either offset raises cnt_wr_lo_o or cnt_wr_hi_o, respectively, during its access phase, with cnt_wdata_o equal to pwdata_i.
- R5: Offsets 0x10 and 0x14 are 32-bit read/write step registers that drive step0_o and step1_o.
- R6: An access whose pprot_i[1] differs from FRAME_NS is a mismatch. It writes nothing, reads 0 and sets the pending flag.
- R7: Any other address, including one whose two low bits are not zero, is a decode error. It writes nothing, reads 0, sets the pending flag and never raises pslverr_o.
- R8: pslverr_o is 1 only in the access phase of a mismatched access while the error-response enable is set.
- R9: The pending flag clears on a valid write of 1 to bit5 of the control word. Writing 0 to bit5 leaves it unchanged, and an error in the same cycle keeps it set. irq_o is high while the flag and the interrupt enable are both set.
- R10: pready_o is always 1, and a setup phase without penable_i changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| pprot_i | input | 3 | APB protection; bit1 set means non-secure |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error response |
| cnt_val_i | input | 64 | Current count from datapath |
| halted_i | input | 1 | Counter halted by debug |
| clk_sel_i | input | 2 | Clock-select code in use |
| cnt_en_o | output | 1 | Count enable |
| halt_dbg_o | output | 1 | Halt-on-debug enable |
| scale_en_o | output | 1 | Scaling enable |
| step0_o | output | 32 | Step value for clock source 0 |
| step1_o | output | 32 | Step value for clock source 1 |
| cnt_wr_lo_o | output | 1 | Load strobe, low count word |
| cnt_wr_hi_o | output | 1 | Load strobe, high count word |
| cnt_wdata_o | output | 32 | Load data for the count word |
| irq_o | output | 1 | Error interrupt |

## Verification
The access patterns cover matched reads and writes of every register, writes to the read-only status, and mismatched reads and writes with the error response on and off. They also cover accesses to an unmapped offset and a misaligned offset. Read data tells a blocked access apart from a valid one. pslverr_o tells a mismatch apart from a decode error. A read-back of the control word after each error shows whether the pending flag was set. Separate sequences cover a write of 0 versus 1 to the pending bit, interrupt gating, the load strobes and a lone setup phase.

// File: rtl/cnt_ctl_pkg.sv
package cnt_ctl_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_CNT_LO, SEL_CNT_HI, SEL_STEP0, SEL_STEP1, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic resp_en;
    logic irq_en;
    logic scale_en;
    logic halt_dbg;
    logic cnt_en;
  } ctrl_t;

  // control word bit positions
  localparam int unsigned CB_CNT_EN   = 0;
  localparam int unsigned CB_HALT_DBG = 1;
  localparam int unsigned CB_SCALE_EN = 2;
  localparam int unsigned CB_IRQ_EN   = 3;
  localparam int unsigned CB_RESP_EN  = 4;
  localparam int unsigned CB_PEND     = 5;
  // status word bit positions
  localparam int unsigned SB_HALTED   = 0;
  localparam int unsigned SB_SCL_IMPL = 1;
  localparam int unsigned SB_SW_IMPL  = 2;
  localparam int unsigned SB_CLK_SEL  = 4;
  localparam int unsigned NUM_REGS    = 6;
endpackage

// File: rtl/cnt_ctl_dec.sv
module cnt_ctl_dec
  import cnt_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] paddr_i,
  output reg_sel_e          sel_o,
  output logic              hit_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = paddr_i[ADDR_W-1:2];
  assign aligned = (paddr_i[1:0] == 2'b00);

  always_comb begin
    sel_o = SEL_NONE;
    if (aligned) begin
      case (idx)
        IDX_W'(0): sel_o = SEL_CTRL;
        IDX_W'(1): sel_o = SEL_STAT;
        IDX_W'(2): sel_o = SEL_CNT_LO;
        IDX_W'(3): sel_o = SEL_CNT_HI;
        IDX_W'(4): sel_o = SEL_STEP0;
        IDX_W'(5): sel_o = SEL_STEP1;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end

  assign hit_o = (sel_o != SEL_NONE);
endmodule

// File: rtl/cnt_ctl_regs.sv
module cnt_ctl_regs
  import cnt_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NSTEP     = 2,
  parameter logic [NSTEP-1:0][DATA_W-1:0] STEP_RST = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  reg_sel_e                     sel_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output ctrl_t                        ctrl_o,
  output logic [NSTEP-1:0][DATA_W-1:0] step_o,
  output logic                         pend_clr_o,
  output logic                         cnt_wr_lo_o,
  output logic                         cnt_wr_hi_o
);
  ctrl_t ctrl_q;
  logic  ctrl_we;

  assign ctrl_we = wr_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.cnt_en   <= wdata_i[CB_CNT_EN];
      ctrl_q.halt_dbg <= wdata_i[CB_HALT_DBG];
      ctrl_q.scale_en <= wdata_i[CB_SCALE_EN];
      ctrl_q.irq_en   <= wdata_i[CB_IRQ_EN];
      ctrl_q.resp_en  <= wdata_i[CB_RESP_EN];
    end
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    reg_sel_e step_sel;
    assign step_sel = (g == 0) ? SEL_STEP0 : SEL_STEP1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        step_o[g] <= STEP_RST[g];
      else if (wr_i && sel_i == step_sel) step_o[g] <= wdata_i;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign pend_clr_o  = ctrl_we && wdata_i[CB_PEND];
  assign cnt_wr_lo_o = wr_i && (sel_i == SEL_CNT_LO);
  assign cnt_wr_hi_o = wr_i && (sel_i == SEL_CNT_HI);

  // R2: control holds unless a valid control write happens
  a_r2_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  // R5: step registers change only through a write
  a_r5_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(step_o));
endmodule

// File: rtl/cnt_ctl_err.sv
module cnt_ctl_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_err_i,
  input  logic dec_err_i,
  input  logic clr_i,
  input  logic resp_en_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic irq_o,
  output logic slverr_o
);
  logic pend_q;
  logic err;

  assign err = sec_err_i || dec_err_i;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (err)   pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o   = pend_q;
  assign irq_o    = pend_q && irq_en_i;
  assign slverr_o = sec_err_i && resp_en_i;

  a_r9_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |=> pend_q);
  a_r9_pend_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !err) |=> !pend_q);
  a_r9_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !err) |=> $stable(pend_q));
endmodule

// File: rtl/cnt_ctl_apb.sv
module cnt_ctl_apb
  import cnt_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter bit          FRAME_NS    = 1'b0,
  parameter bit          SCALE_IMPL  = 1'b1,
  parameter bit          SWITCH_IMPL = 1'b0,
  parameter logic [31:0] STEP0_RST   = 32'h0100_0000,
  parameter logic [31:0] STEP1_RST   = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  input  logic [2:0]        pprot_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [63:0]       cnt_val_i,
  input  logic              halted_i,
  input  logic [1:0]        clk_sel_i,
  output logic              cnt_en_o,
  output logic              halt_dbg_o,
  output logic              scale_en_o,
  output logic [31:0]       step0_o,
  output logic [31:0]       step1_o,
  output logic              cnt_wr_lo_o,
  output logic              cnt_wr_hi_o,
  output logic [31:0]       cnt_wdata_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSTEP  = 2;
  localparam int unsigned CNT_W  = 2 * DATA_W;

  reg_sel_e                     sel;
  logic                         hit, access, mismatch, sec_err, dec_err;
  logic                         wr_ok, rd_ok, pend, pend_clr;
  ctrl_t                        ctrl;
  logic [NSTEP-1:0][DATA_W-1:0] step;
  logic [DATA_W-1:0]            rd;

  assign access   = psel_i && penable_i;
  assign mismatch = (pprot_i[1] != FRAME_NS);
  assign sec_err  = access && mismatch;
  assign dec_err  = access && !mismatch && !hit;
  assign wr_ok    = access && pwrite_i && !mismatch && hit;
  assign rd_ok    = access && !pwrite_i && !mismatch && hit;

  cnt_ctl_dec #(.ADDR_W(ADDR_W)) u_dec (
    .paddr_i (paddr_i),
    .sel_o   (sel),
    .hit_o   (hit)
  );

  cnt_ctl_regs #(
    .DATA_W   (DATA_W),
    .NSTEP    (NSTEP),
    .STEP_RST ({STEP1_RST, STEP0_RST})
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ok),
    .sel_i       (sel),
    .wdata_i     (pwdata_i),
    .ctrl_o      (ctrl),
    .step_o      (step),
    .pend_clr_o  (pend_clr),
    .cnt_wr_lo_o (cnt_wr_lo_o),
    .cnt_wr_hi_o (cnt_wr_hi_o)
  );

  cnt_ctl_err u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_err_i (sec_err),
    .dec_err_i (dec_err),
    .clr_i     (pend_clr),
    .resp_en_i (ctrl.resp_en),
    .irq_en_i  (ctrl.irq_en),
    .pend_o    (pend),
    .irq_o     (irq_o),
    .slverr_o  (pslverr_o)
  );

  always_comb begin
    rd = '0;
    case (sel)
      SEL_CTRL: begin
        rd[CB_CNT_EN]   = ctrl.cnt_en;
        rd[CB_HALT_DBG] = ctrl.halt_dbg;
        rd[CB_SCALE_EN] = ctrl.scale_en;
        rd[CB_IRQ_EN]   = ctrl.irq_en;
        rd[CB_RESP_EN]  = ctrl.resp_en;
        rd[CB_PEND]     = pend;
      end
      SEL_STAT: begin
        rd[SB_HALTED]       = halted_i;
        rd[SB_SCL_IMPL]     = SCALE_IMPL;
        rd[SB_SW_IMPL]      = SWITCH_IMPL;
        rd[SB_CLK_SEL +: 2] = clk_sel_i;
      end
      SEL_CNT_LO: rd = cnt_val_i[DATA_W-1:0];
      SEL_CNT_HI: rd = cnt_val_i[CNT_W-1:DATA_W];
      SEL_STEP0:  rd = step[0];
      SEL_STEP1:  rd = step[1];
      default:    rd = '0;
    endcase
  end

  assign prdata_o    = rd_ok ? rd : '0;
  assign pready_o    = 1'b1;
  assign cnt_en_o    = ctrl.cnt_en;
  assign halt_dbg_o  = ctrl.halt_dbg;
  assign scale_en_o  = ctrl.scale_en;
  assign step0_o     = step[0];
  assign step1_o     = step[1];
  assign cnt_wdata_o = pwdata_i;

  a_r8_slverr_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (psel_i && penable_i && pprot_i[1] != FRAME_NS));
  a_r7_dec_no_slverr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !hit && !mismatch) |-> !pslverr_o);
  a_r6_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !pwrite_i && (mismatch || !hit)) |-> (prdata_o == '0));
  a_r6_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && mismatch) |=> ($stable(step0_o) && $stable(step1_o) && $stable(cnt_en_o)));
  a_r4_lo_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_lo_o |-> (access && pwrite_i && paddr_i == ADDR_W'(8)));
  a_r10_setup_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !penable_i |=> ($stable(step0_o) && $stable(cnt_en_o)));
endmodule

// File: tb/cnt_ctl_apb_tb.sv
module cnt_ctl_apb_tb_top;
  localparam int unsigned AW = 12;
  localparam logic [31:0] S0 = 32'h0100_0000;
  localparam logic [31:0] S1 = 32'h0200_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, pen = 0, pwr = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [2:0] pprot = '0;
  logic pready, pslverr;
  logic [63:0] cnt_val = 64'h1122_3344_5566_7788;
  logic halted = 1'b0;
  logic [1:0] clk_sel = 2'b01;
  logic cnt_en, halt_dbg, scale_en, wr_lo, wr_hi, irq;
  logic [31:0] step0, step1, cnt_wd;
  int n_run = 0, n_fail = 0;
  logic cap_lo, cap_hi, cap_err;
  logic [31:0] cap_wd, cap_rd;

  always #5 clk = ~clk;

  cnt_ctl_apb #(.ADDR_W(AW), .STEP0_RST(S0), .STEP1_RST(S1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .pprot_i(pprot), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .cnt_val_i(cnt_val), .halted_i(halted),
    .clk_sel_i(clk_sel), .cnt_en_o(cnt_en), .halt_dbg_o(halt_dbg), .scale_en_o(scale_en),
    .step0_o(step0), .step1_o(step1), .cnt_wr_lo_o(wr_lo), .cnt_wr_hi_o(wr_hi),
    .cnt_wdata_o(cnt_wd), .irq_o(irq));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic w, input logic [AW-1:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    psel = 1; pen = 0; pwr = w; paddr = a; pwdata = d; pprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    pen = 1; #1;
    cap_rd = prdata; cap_err = pslverr; cap_lo = wr_lo; cap_hi = wr_hi; cap_wd = cnt_wd;
    @(negedge clk);
    psel = 0; pen = 0; pwr = 0;
  endtask

  // {write, addr, wdata, ns, exp_rdata, exp_slverr, req}
  localparam int NV = 25;
  localparam logic [82:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h0000_001F, 1'b0, 32'h0,         1'b0, 4'd2},  // R2 set all control
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_001F, 1'b0, 4'd2},  // R2 readback
    {1'b1, 12'h010, 32'hA5A5_0001, 1'b0, 32'h0,         1'b0, 4'd5},  // R5
    {1'b0, 12'h010, 32'h0,         1'b0, 32'hA5A5_0001, 1'b0, 4'd5},  // R5
    {1'b0, 12'h014, 32'h0,         1'b0, 32'h0200_0000, 1'b0, 4'd5},  // R5 reset value
    {1'b0, 12'h008, 32'h0,         1'b0, 32'h5566_7788, 1'b0, 4'd4},  // R4 low word
    {1'b0, 12'h00C, 32'h0,         1'b0, 32'h1122_3344, 1'b0, 4'd4},  // R4 high word
    {1'b0, 12'h004, 32'h0,         1'b0, 32'h0000_0012, 1'b0, 4'd3},  // R3 status
    {1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 4'd3},  // R3 write ignored
    {1'b0, 12'h004, 32'h0,         1'b0, 32'h0000_0012, 1'b0, 4'd3},  // R3
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_001F, 1'b0, 4'd3},  // R3 no pending
    {1'b0, 12'h010, 32'h0,         1'b1, 32'h0,         1'b1, 4'd6},  // R6 mismatch read
    {1'b1, 12'h010, 32'h0,         1'b1, 32'h0,         1'b1, 4'd6},  // R6 mismatch write
    {1'b0, 12'h010, 32'h0,         1'b0, 32'hA5A5_0001, 1'b0, 4'd6},  // R6 unchanged
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_003F, 1'b0, 4'd6},  // R6 pending set
    {1'b1, 12'h000, 32'h0000_003F, 1'b0, 32'h0,         1'b0, 4'd9},  // R9 W1C
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_001F, 1'b0, 4'd9},  // R9 cleared
    {1'b0, 12'h018, 32'h0,         1'b0, 32'h0,         1'b0, 4'd7},  // R7 unmapped read
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_003F, 1'b0, 4'd7},  // R7 pending set
    {1'b1, 12'h012, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 4'd7},  // R7 misaligned write
    {1'b1, 12'h000, 32'h0000_001F, 1'b0, 32'h0,         1'b0, 4'd9},  // R9 write 0 to pend
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_003F, 1'b0, 4'd9},  // R9 still pending
    {1'b1, 12'h000, 32'h0000_0020, 1'b0, 32'h0,         1'b0, 4'd9},  // R9 clear, all off
    {1'b0, 12'h040, 32'h0,         1'b1, 32'h0,         1'b0, 4'd8},  // R8 response disabled
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_0020, 1'b0, 4'd8}   // R8 pending set
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 outputs", {cnt_en, halt_dbg, scale_en, irq, pslverr, pready}, 64'h1);
    check("R1 step0", step0, S0);
    check("R1 step1", step1, S1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      apb(v[82], v[81:70], v[69:38], v[37]);
      if (!v[82]) check($sformatf("R%0d rdata vec%0d", v[3:0], i), cap_rd, v[36:5]);
      check($sformatf("R%0d slverr vec%0d", v[3:0], i), cap_err, v[4]);
    end

    // R2 outputs follow control bits
    apb(1, 12'h000, 32'h0000_0007, 0);
    check("R2 outputs", {cnt_en, halt_dbg, scale_en}, 64'h7);
    // R5 step outputs
    check("R5 step0_o", step0, 32'hA5A5_0001);

    // R4 load strobes
    apb(1, 12'h008, 32'hDEAD_0001, 0);
    check("R4 lo strobe", {cap_lo, cap_hi, cap_wd}, {2'b10, 32'hDEAD_0001});
    apb(1, 12'h00C, 32'hBEEF_0002, 0);
    check("R4 hi strobe", {cap_lo, cap_hi, cap_wd}, {2'b01, 32'hBEEF_0002});
    apb(1, 12'h00C, 32'h1, 1);
    check("R4 R6 mismatch no strobe", {cap_lo, cap_hi}, 64'h0);

    // R9 interrupt gating (pending set by the mismatch above)
    check("R9 irq disabled", irq, 1'b0);
    apb(1, 12'h000, 32'h0000_0018, 0);
    check("R9 irq enabled", irq, 1'b1);
    apb(1, 12'h000, 32'h0000_0010, 0);
    check("R9 irq masked", irq, 1'b0);
    apb(1, 12'h000, 32'h0000_0038, 0);
    check("R9 irq cleared", irq, 1'b0);

    // R3 status inputs tracked
    halted = 1'b1; clk_sel = 2'b10;
    apb(0, 12'h004, 32'h0, 0);
    check("R3 status live", cap_rd, 32'h0000_0023);

    // R10 setup phase alone changes nothing
    @(negedge clk);
    psel = 1; pen = 0; pwr = 1; paddr = 12'h010; pwdata = 32'h0; pprot = 3'b000;
    @(negedge clk);
    psel = 0; pwr = 0;
    @(negedge clk);
    check("R10 setup only", step0, 32'hA5A5_0001);
    check("R10 pready", pready, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule